// File: doc/BRIEF.md
# Periodic Tick Timer

A memory-mapped tick timer for a processor board. A prescaler divides the system clock down to a 1 MHz tick. Each enabled tick advances a 32-bit up-counter. When the advanced value equals a 32-bit compare register, the block records a match. A match bumps a 4-bit overflow tally, sets an interrupt pending flag and, if clear-on-compare is on, returns the counter to zero. With clear-on-compare on, the counter period is exactly the compare value in ticks.

Software runs the block over a simple register bus: a word address, a write strobe, four byte enables, and write and read data. The interrupt request leaves the block together with a 3-bit priority level. The counter is reset and the tally is advanced on the same clock edge. Software can therefore read the tally, then the counter, then the tally again, and rebuild a continuous time base from those reads.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads zero, counting is stopped, and `irq_o` and `irq_level_o` are 0.
- R2: The registers are big-endian 32-bit words: compare at 0x04, counter at 0x08, control byte at 0x17, interrupt-control byte at 0x1b. Byte offset k of a word sits on lane `be_i[3-k]`, that is `wdata_i`/`rdata_o` bits 8*(3-k)+7 : 8*(3-k). A write changes only the lanes it enables. Any access with `addr_i[1:0]` nonzero selects nothing and reads zero.
- R3: Control bit 0 enables counting. While enabled, the counter advances by one every PRESCALE clocks, and the prescaler phase restarts at the edge that enables counting. While disabled, the counter holds its value.
- R4: A match occurs on a tick whose incremented counter value equals the compare value. With clear-on-compare (control bit 1) set, the counter takes 0 on that tick instead of the compare value.
- R5: With clear-on-compare clear, a match still advances the tally, and the counter keeps counting upward past the compare value.
- R6: The tally reads in control bits 7:4 and wraps modulo 16. Control bits 1:0 read back as written, and bits 3:2 read zero.
- R7: Writing 1 to control bit 2 zeroes the tally. If a match falls in the same cycle, the clear takes priority.
- R8: A bus write to the counter takes priority over a tick in the same cycle, so zeroing the counter while it runs restarts the count from zero.
- R9: With clear-on-compare set, the tally advance and the counter's return to zero take effect on the same clock edge.
- R10: Every match sets the pending flag, which reads back in interrupt-control bit 3. Writing 1 to that bit clears the flag, but a match in the same cycle wins and the flag stays set.
- R11: `irq_o` is 1 only when the flag is pending, the interrupt enable (interrupt-control bit 4) is set, and the level (interrupt-control bits 2:0) is nonzero. `irq_level_o` carries the level while `irq_o` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte address of the access |
| we_i | input | 1 | Write strobe |
| be_i | input | 4 | Byte lane enables, be_i[3] = byte offset 0 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Priority level of the request |

## Verification
The embedded properties watch several behaviours on every cycle:
- single-step advance and hold of the counter;
- the return to zero on a clearing match;
- the tally clear and its same-edge coupling with the counter wrap;
- pending set and clear;
- the rule that the request carries a nonzero level only while pending.

Other behaviours show up only in the bench's scenarios. These are the byte-lane merging at the register offsets, the prescaler rate measured over many ticks, the modulo-16 tally wrap, and the write-versus-tick priority on the counter. The same holds for the two same-cycle races, tally clear against match and pending clear against match, which the bench lines up on exact tick edges.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int BUS_W   = 32;
  localparam int LANES   = BUS_W / 8;
  localparam int ADDR_W  = 5;
  localparam int TALLY_W = 4;
  localparam int LVL_W   = 3;

  // word indices (byte address >> 2)
  localparam logic [2:0] WRD_CMP  = 3'd1;
  localparam logic [2:0] WRD_CNT  = 3'd2;
  localparam logic [2:0] WRD_CTL  = 3'd5;
  localparam logic [2:0] WRD_ICTL = 3'd6;

  // control byte bits
  localparam int CTL_RUN  = 0;
  localparam int CTL_COC  = 1;
  localparam int CTL_TCLR = 2;
  // interrupt-control byte bits
  localparam int ICTL_PCLR = 3;
  localparam int ICTL_IE   = 4;

  typedef struct packed {
    logic coc;
    logic run;
  } ctl_t;

  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] cur,
                                                  input logic [BUS_W-1:0] nxt,
                                                  input logic [LANES-1:0] be);
    logic [BUS_W-1:0] r;
    r = cur;
    for (int l = 0; l < LANES; l++) begin
      if (be[l]) r[l*8 +: 8] = nxt[l*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRESCALE = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PW-1:0] ph_q;
      logic          last;
      assign last   = (ph_q == PW'(PRESCALE - 1));
      assign tick_o = en_i && last;

      // phase held at zero while stopped so a restart is deterministic
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        ph_q <= '0;
        else if (!en_i)     ph_q <= '0;
        else if (last)      ph_q <= '0;
        else                ph_q <= ph_q + PW'(1);
      end

      AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R3
    end else begin : g_pass
      assign tick_o = en_i;
    end
  endgenerate
endmodule

// File: rtl/tick_count_core.sv
module tick_count_core #(
  parameter int CNT_W   = 32,
  parameter int TALLY_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               coc_i,
  input  logic               cnt_we_i,
  input  logic [CNT_W-1:0]   cnt_wdata_i,
  input  logic               tally_clr_i,
  input  logic [CNT_W-1:0]   cmp_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [TALLY_W-1:0] tally_o,
  output logic               hit_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [TALLY_W-1:0] tally_q;
  logic [CNT_W-1:0]   inc;

  assign inc   = cnt_q + CNT_W'(1);
  assign hit_o = tick_i && (inc == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= cnt_wdata_i;
    else if (tick_i)   cnt_q <= (hit_o && coc_i) ? '0 : inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tally_q <= '0;
    else if (tally_clr_i) tally_q <= '0;
    else if (hit_o)       tally_q <= tally_q + TALLY_W'(1);
  end

  assign cnt_o   = cnt_q;
  assign tally_o = tally_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !cnt_we_i && !(hit_o && coc_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !cnt_we_i |=> $stable(cnt_q)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && coc_i && !cnt_we_i |=> cnt_q == '0); // R4
  AST_TALLY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tally_clr_i |=> tally_q == '0); // R7
  AST_TALLY_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && coc_i && !cnt_we_i && !tally_clr_i
    |=> (tally_q == $past(tally_q) + TALLY_W'(1)) && (cnt_q == '0)); // R9
endmodule

// File: rtl/tick_irq_ctl.sv
module tick_irq_ctl #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             wr_i,
  input  logic [LVL_W-1:0] lvl_wdata_i,
  input  logic             ie_wdata_i,
  input  logic             pclr_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             ie_o,
  output logic             pend_o,
  output logic             irq_o,
  output logic [LVL_W-1:0] irq_level_o
);
  logic [LVL_W-1:0] lvl_q;
  logic             ie_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      ie_q  <= 1'b0;
    end else if (wr_i) begin
      lvl_q <= lvl_wdata_i;
      ie_q  <= ie_wdata_i;
    end
  end

  // a match in the clearing cycle keeps the flag set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= 1'b0;
    else if (hit_i)           pend_q <= 1'b1;
    else if (wr_i && pclr_i)  pend_q <= 1'b0;
  end

  assign irq_o       = pend_q && ie_q && (lvl_q != '0);
  assign irq_level_o = irq_o ? lvl_q : '0;
  assign lvl_o       = lvl_q;
  assign ie_o        = ie_q;
  assign pend_o      = pend_q;

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> pend_q); // R10
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && pclr_i && !hit_i |=> !pend_q); // R10
  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_level_o != '0); // R11
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |-> !irq_o && irq_level_o == '0); // R11
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int PRESCALE = 250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_level_o
);
  logic [2:0]         wrd;
  logic               aligned;
  logic [BUS_W-1:0]   cmp_q;
  ctl_t               ctl_q;
  logic               tick;
  logic [BUS_W-1:0]   cnt;
  logic [TALLY_W-1:0] tally;
  logic               hit;
  logic               cmp_we, cnt_we, ctl_we, ictl_we;
  logic [LVL_W-1:0]   lvl;
  logic               ie, pend;

  assign wrd     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign cmp_we  = we_i && aligned && (wrd == WRD_CMP) && (|be_i);
  assign cnt_we  = we_i && aligned && (wrd == WRD_CNT) && (|be_i);
  assign ctl_we  = we_i && aligned && (wrd == WRD_CTL) && be_i[0];
  assign ictl_we = we_i && aligned && (wrd == WRD_ICTL) && be_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '0;
    else if (cmp_we) cmp_q <= lane_merge(cmp_q, wdata_i, be_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_we) ctl_q <= '{coc: wdata_i[CTL_COC], run: wdata_i[CTL_RUN]};
  end

  tick_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctl_q.run),
    .tick_o (tick)
  );

  tick_count_core #(.CNT_W(BUS_W), .TALLY_W(TALLY_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .coc_i       (ctl_q.coc),
    .cnt_we_i    (cnt_we),
    .cnt_wdata_i (lane_merge(cnt, wdata_i, be_i)),
    .tally_clr_i (ctl_we && wdata_i[CTL_TCLR]),
    .cmp_i       (cmp_q),
    .cnt_o       (cnt),
    .tally_o     (tally),
    .hit_o       (hit)
  );

  tick_irq_ctl #(.LVL_W(LVL_W)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .wr_i        (ictl_we),
    .lvl_wdata_i (wdata_i[LVL_W-1:0]),
    .ie_wdata_i  (wdata_i[ICTL_IE]),
    .pclr_i      (wdata_i[ICTL_PCLR]),
    .lvl_o       (lvl),
    .ie_o        (ie),
    .pend_o      (pend),
    .irq_o       (irq_o),
    .irq_level_o (irq_level_o)
  );

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (wrd)
        WRD_CMP:  rdata_o = cmp_q;
        WRD_CNT:  rdata_o = cnt;
        WRD_CTL:  rdata_o[7:0] = {tally, 2'b00, ctl_q.coc, ctl_q.run};
        WRD_ICTL: rdata_o[7:0] = {3'b000, ie, pend, lvl};
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  localparam int P = 4;
  localparam logic [4:0] A_CMP = 5'h04, A_CNT = 5'h08, A_CTL = 5'h14, A_ICTL = 5'h18;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic [2:0]  irq_level_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // scoreboard queues: kind (0 read data, 1 irq pins), expected value, requirement
  bit          kind_q[$];
  logic [31:0] exp_q[$];
  string       req_q[$];
  bit          smp_req = 0;

  always #2 clk_i = ~clk_i;

  tick_timer #(.PRESCALE(P)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .irq_level_o(irq_level_o)
  );

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      if (smp_req) begin
        bit          k;
        logic [31:0] e, a;
        string       r;
        k = kind_q.pop_front();
        e = exp_q.pop_front();
        r = req_q.pop_front();
        a = k ? {28'd0, irq_o, irq_level_o} : rdata_o;
        total++;
        if (a !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", r, a, e);
        end
        smp_req = 0;
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; be_i = be; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    #1 we_i = 1'b0; be_i = '0;
  endtask

  task automatic push(input bit k, input logic [4:0] a, input logic [31:0] e, input string r);
    addr_i = a;
    kind_q.push_back(k);
    exp_q.push_back(e);
    req_q.push_back(r);
    smp_req = 1;
    @(negedge clk_i);
    #1;
  endtask

  task automatic chk(input logic [4:0] a, input logic [31:0] e, input string r);
    push(1'b0, a, e, r);
  endtask

  task automatic chk_irq(input logic [3:0] e, input string r);
    push(1'b1, addr_i, {28'd0, e}, r);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk(A_CMP, 32'h0, "R1 cmp");
    chk(A_CNT, 32'h0, "R1 cnt");
    chk(A_CTL, 32'h0, "R1 ctl");
    chk(A_ICTL, 32'h0, "R1 ictl");
    chk_irq(4'h0, "R1 irq");

    // R2 lanes and offsets
    wr(A_CMP, 4'hF, 32'h11223344);
    wr(A_CMP, 4'h1, 32'h000000AA);
    chk(A_CMP, 32'h112233AA, "R2 low lane");
    wr(A_CMP, 4'h8, 32'hCC000000);
    chk(A_CMP, 32'hCC2233AA, "R2 high lane");
    wr(A_CTL, 4'h2, 32'h0000FF00);
    chk(A_CTL, 32'h0, "R2 unselected lane");
    wr(5'h09, 4'hF, 32'hFFFFFFFF);
    chk(A_CNT, 32'h0, "R2 misaligned write");

    // R3 count rate and hold
    wr(A_CNT, 4'hF, 0); wr(A_CMP, 4'hF, 0);
    wr(A_CTL, 4'h1, 32'h01); idle(39); wr(A_CTL, 4'h1, 32'h00);
    chk(A_CNT, 32'd10, "R3 rate");
    idle(20);
    chk(A_CNT, 32'd10, "R3 hold");

    // R4 clear on compare, period = compare
    wr(A_CNT, 4'hF, 0); wr(A_CMP, 4'hF, 5);
    wr(A_CTL, 4'h1, 32'h07); idle(47); wr(A_CTL, 4'h1, 32'h02);
    chk(A_CNT, 32'd2, "R4 cnt after two wraps");
    chk(A_CTL, 32'h22, "R6 tally=2 coc readback");
    chk(A_ICTL, 32'h08, "R10 pending set");
    chk_irq(4'h0, "R11 masked");

    // R7 clear, R5 free run past compare
    wr(A_CTL, 4'h1, 32'h04);
    chk(A_CTL, 32'h00, "R7 tally clear");
    wr(A_CNT, 4'hF, 0); wr(A_CMP, 4'hF, 3);
    wr(A_CTL, 4'h1, 32'h01); idle(19); wr(A_CTL, 4'h1, 32'h00);
    chk(A_CNT, 32'd5, "R5 counts past compare");
    chk(A_CTL, 32'h10, "R5 tally one");

    // R6 modulo 16, R9 coupling
    wr(A_CTL, 4'h1, 32'h04); wr(A_CNT, 4'hF, 0); wr(A_CMP, 4'hF, 1);
    wr(A_CTL, 4'h1, 32'h03); idle(67); wr(A_CTL, 4'h1, 32'h02);
    chk(A_CNT, 32'd0, "R9 cnt zero with tally");
    chk(A_CTL, 32'h12, "R6 tally wrap 17->1");

    // R7 clear beats a match on the same edge
    wr(A_CTL, 4'h1, 32'h03); idle(3); wr(A_CTL, 4'h1, 32'h06);
    chk(A_CTL, 32'h02, "R7 clear priority");

    // R8 write beats tick, restart from zero
    wr(A_CMP, 4'hF, 0); wr(A_CNT, 4'hF, 32'h50);
    wr(A_CTL, 4'h1, 32'h01); idle(7); wr(A_CNT, 4'hF, 0);
    idle(11); wr(A_CTL, 4'h1, 32'h00);
    chk(A_CNT, 32'd3, "R8 restart");

    // R10 / R11 interrupt path
    wr(A_ICTL, 4'h1, 32'h08);
    chk(A_ICTL, 32'h00, "R10 w1c");
    wr(A_ICTL, 4'h1, 32'h15);
    chk_irq(4'h0, "R11 no pending");
    wr(A_CNT, 4'hF, 0); wr(A_CMP, 4'hF, 2);
    wr(A_CTL, 4'h1, 32'h07); idle(7); wr(A_CTL, 4'h1, 32'h02);
    chk_irq(4'hD, "R11 request level 5");
    chk(A_ICTL, 32'h1D, "R10 pending readback");
    wr(A_ICTL, 4'h1, 32'h10);
    chk_irq(4'h0, "R11 level zero masks");
    wr(A_ICTL, 4'h1, 32'h05);
    chk_irq(4'h0, "R11 enable off masks");
    chk(A_ICTL, 32'h0D, "R10 pending kept");
    wr(A_ICTL, 4'h1, 32'h1D);
    chk(A_ICTL, 32'h15, "R10 cleared");
    chk_irq(4'h0, "R11 cleared");

    // R10 set beats clear on the same edge
    wr(A_CNT, 4'hF, 0); wr(A_CMP, 4'hF, 1);
    wr(A_CTL, 4'h1, 32'h03); idle(3); wr(A_ICTL, 4'h1, 32'h1D);
    wr(A_CTL, 4'h1, 32'h02);
    chk(A_ICTL, 32'h1D, "R10 set priority");
    chk_irq(4'hD, "R11 request after race");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule